// File: doc/BRIEF.md
# Pedestrian Crossing Signal Controller

This block sequences a road crossing. It drives three vehicle lamps (green, amber, red) and two pedestrian lamps (green, red). It also drives two decimal digits that count down the crossing time. Vehicles keep green until a pedestrian presses the request button. The block then runs a fixed timed sequence: vehicle amber, an all-red clearance, a steady pedestrian walk phase, a flashing warning phase and a second clearance. After that it returns to vehicle green.

The whole sequence is timed by one down-counter that starts at the total sequence length in seconds. Each phase ends when that counter reaches a fixed remaining-time value. A second down-counter holds the seconds left to cross. Its value is converted to two BCD nibbles. A one-second tick and a blink tick come from outside the block, and so do button debouncing and seven-segment scanning. Every output is registered.

Top module: `ped_xing_ctrl`

## Requirements
- R1: While reset is held and after it is released, vehicle green and pedestrian red are on and every other lamp is off. Both digits hold the blank code 4'b1111. With no request, this idle condition persists.
- R2: A request (`req_btn` high for one clock) in idle turns on vehicle amber and turns off vehicle green on the next clock edge.
- R3: After the request, the phases last 3, 1, 15, 5 and 1 `sec_tick` pulses: amber, clearance (vehicle red and pedestrian red), walk, warning, clearance. The block then returns to idle. Each change appears on the clock edge at which the final tick of the phase is sampled.
- R4: Exactly one vehicle lamp is on at any time. The two pedestrian lamps are never on together. Pedestrian green is only ever on while vehicle red is on.
- R5: On entry to walk, the digits read 1 (`dig_hi`, tens) and 5 (`dig_lo`, units). The value drops by one on each tick in walk, reaches 0 and 0 on entry to the warning phase, and holds there.
- R6: The blink level starts low at reset and toggles on every `blink_tick`. In the warning phase, while blink is low, pedestrian green is on and the digits show the count. While blink is high, both pedestrian lamps are off and both digits are 4'b1111.
- R7: A request made while a sequence is running is remembered. The next sequence starts, with vehicle amber, one clock after the block returns to idle.
- R8: In idle, `sec_tick` pulses have no effect. A sequence that starts after any amount of idle time still gives exactly 3 ticks of amber.
- R9: Outside the walk and warning phases, both digits are 4'b1111.
- R10: A synchronous reset in the middle of a sequence returns the block to idle and discards any remembered request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_btn | input | 1 | Debounced pedestrian request, one-clock pulse or level |
| sec_tick | input | 1 | One-clock pulse once per second |
| blink_tick | input | 1 | One-clock pulse at each half period of the flash rate |
| veh_grn | output | 1 | Vehicle green lamp |
| veh_amb | output | 1 | Vehicle amber lamp |
| veh_red | output | 1 | Vehicle red lamp |
| ped_grn | output | 1 | Pedestrian green lamp |
| ped_red | output | 1 | Pedestrian red lamp |
| dig_hi | output | 4 | Tens digit of crossing time, BCD, 4'b1111 when blank |
| dig_lo | output | 4 | Units digit of crossing time, BCD, 4'b1111 when blank |

## Verification
The embedded properties check the following on every clock:
- lamp exclusivity;
- blank digits outside the crossing phases;
- the dark pedestrian side during the high half of the warning flash;
- amber being entered only from green;
- the sequence counter held at its load value in idle.

The bench's scenarios are needed for the behaviour that depends on history:
- phase lengths counted in ticks;
- the digit countdown values;
- a request remembered across a running sequence and served one clock after idle;
- idle ticks having no effect on later timing;
- a reset that discards a remembered request.

// File: rtl/ped_xing_pkg.sv
package ped_xing_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AMBER,
        ST_CLEAR_IN,
        ST_WALK,
        ST_WARN,
        ST_CLEAR_OUT
    } xing_state_e;

    typedef struct packed {
        logic       veh_grn;
        logic       veh_amb;
        logic       veh_red;
        logic       ped_grn;
        logic       ped_red;
        logic [3:0] dig_hi;
        logic [3:0] dig_lo;
    } xing_out_t;

    localparam logic [3:0] DIGIT_BLANK = 4'b1111;

endpackage

// File: rtl/xing_countdown.sv
module xing_countdown #(
    parameter int LOAD = 25,
    localparam int W = $clog2(LOAD + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         en,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d
);
    localparam logic [W-1:0] LOAD_V = W'(LOAD);

    always_comb begin
        cnt_d = cnt_q;
        if (hold)
            cnt_d = LOAD_V;
        else if (en)
            cnt_d = (cnt_q == '0) ? LOAD_V : cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= LOAD_V;
        else     cnt_q <= cnt_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD_V); // R3

endmodule

// File: rtl/xing_bin2bcd.sv
module xing_bin2bcd #(
    parameter int W = 5
) (
    input  logic [W-1:0] bin,
    output logic [3:0]   tens,
    output logic [3:0]   ones
);
    logic [W+7:0] sh;

    always_comb begin
        sh = {8'b0, bin};
        for (int i = 0; i < W; i++) begin
            if (sh[W+3 -: 4] >= 4'd5) sh[W+3 -: 4] = sh[W+3 -: 4] + 4'd3;
            if (sh[W+7 -: 4] >= 4'd5) sh[W+7 -: 4] = sh[W+7 -: 4] + 4'd3;
            sh = sh << 1;
        end
        ones = sh[W+3 -: 4];
        tens = sh[W+7 -: 4];
    end

endmodule

// File: rtl/ped_xing_ctrl.sv
module ped_xing_ctrl
    import ped_xing_pkg::*;
#(
    parameter int AMBER_S     = 3,
    parameter int CLEAR_IN_S  = 1,
    parameter int WALK_S      = 15,
    parameter int WARN_S      = 5,
    parameter int CLEAR_OUT_S = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_btn,
    input  logic       sec_tick,
    input  logic       blink_tick,
    output logic       veh_grn,
    output logic       veh_amb,
    output logic       veh_red,
    output logic       ped_grn,
    output logic       ped_red,
    output logic [3:0] dig_hi,
    output logic [3:0] dig_lo
);
    localparam int SEQ_LOAD = AMBER_S + CLEAR_IN_S + WALK_S + WARN_S + CLEAR_OUT_S;
    localparam int SEQ_W    = $clog2(SEQ_LOAD + 1);
    localparam int XING_W   = $clog2(WALK_S + 1);
    // Remaining-time value at which the last tick of each phase is seen
    localparam logic [SEQ_W-1:0] TH_AMBER     = SEQ_W'(SEQ_LOAD - AMBER_S + 1);
    localparam logic [SEQ_W-1:0] TH_CLEAR_IN  = SEQ_W'(SEQ_LOAD - AMBER_S - CLEAR_IN_S + 1);
    localparam logic [SEQ_W-1:0] TH_WALK      = SEQ_W'(WARN_S + CLEAR_OUT_S + 1);
    localparam logic [SEQ_W-1:0] TH_WARN      = SEQ_W'(CLEAR_OUT_S + 1);
    localparam logic [SEQ_W-1:0] TH_CLEAR_OUT = SEQ_W'(1);

    typedef struct packed {
        xing_state_e st;
        logic        pend;
        logic        blink;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    xing_out_t        out_d, out_q;
    logic [SEQ_W-1:0] seq_q, seq_d;
    logic [XING_W-1:0] xing_q, xing_d;
    logic [3:0]       bcd_tens, bcd_ones;
    logic             in_cross_q;

    assign in_cross_q = (ctl_q.st == ST_WALK) || (ctl_q.st == ST_WARN);

    xing_countdown #(.LOAD(SEQ_LOAD)) u_seq_cnt (
        .clk   (clk),
        .rst   (rst),
        .hold  (ctl_q.st == ST_IDLE),
        .en    (sec_tick),
        .cnt_q (seq_q),
        .cnt_d (seq_d)
    );

    xing_countdown #(.LOAD(WALK_S)) u_xing_cnt (
        .clk   (clk),
        .rst   (rst),
        .hold  (!in_cross_q),
        .en    (sec_tick && (ctl_q.st == ST_WALK)),
        .cnt_q (xing_q),
        .cnt_d (xing_d)
    );

    xing_bin2bcd #(.W(XING_W)) u_bcd (
        .bin  (xing_d),
        .tens (bcd_tens),
        .ones (bcd_ones)
    );

    // Next-state decoder
    always_comb begin
        ctl_d = ctl_q;
        if (blink_tick) ctl_d.blink = ~ctl_q.blink;
        if (req_btn)    ctl_d.pend  = 1'b1;
        unique case (ctl_q.st)
            ST_IDLE:
                if (ctl_q.pend || req_btn) begin
                    ctl_d.st   = ST_AMBER;
                    ctl_d.pend = 1'b0;
                end
            ST_AMBER:     if (sec_tick && seq_q == TH_AMBER)     ctl_d.st = ST_CLEAR_IN;
            ST_CLEAR_IN:  if (sec_tick && seq_q == TH_CLEAR_IN)  ctl_d.st = ST_WALK;
            ST_WALK:      if (sec_tick && seq_q == TH_WALK)      ctl_d.st = ST_WARN;
            ST_WARN:      if (sec_tick && seq_q == TH_WARN)      ctl_d.st = ST_CLEAR_OUT;
            ST_CLEAR_OUT: if (sec_tick && seq_q == TH_CLEAR_OUT) ctl_d.st = ST_IDLE;
            default:      ctl_d.st = ST_IDLE;
        endcase
    end

    // Output decoder, from the next state so outputs line up with ctl_q
    always_comb begin
        logic show;
        show          = (ctl_d.st == ST_WALK) || (ctl_d.st == ST_WARN && !ctl_d.blink);
        out_d.veh_grn = (ctl_d.st == ST_IDLE);
        out_d.veh_amb = (ctl_d.st == ST_AMBER);
        out_d.veh_red = !(ctl_d.st == ST_IDLE || ctl_d.st == ST_AMBER);
        out_d.ped_grn = show;
        out_d.ped_red = !(ctl_d.st == ST_WALK || ctl_d.st == ST_WARN);
        out_d.dig_hi  = show ? bcd_tens : DIGIT_BLANK;
        out_d.dig_lo  = show ? bcd_ones : DIGIT_BLANK;
    end

    // Registered state and output stage
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: ST_IDLE, pend: 1'b0, blink: 1'b0};
            out_q <= '{veh_grn: 1'b1, veh_amb: 1'b0, veh_red: 1'b0,
                       ped_grn: 1'b0, ped_red: 1'b1,
                       dig_hi: DIGIT_BLANK, dig_lo: DIGIT_BLANK};
        end else begin
            ctl_q <= ctl_d;
            out_q <= out_d;
        end
    end

    assign veh_grn = out_q.veh_grn;
    assign veh_amb = out_q.veh_amb;
    assign veh_red = out_q.veh_red;
    assign ped_grn = out_q.ped_grn;
    assign ped_red = out_q.ped_red;
    assign dig_hi  = out_q.dig_hi;
    assign dig_lo  = out_q.dig_lo;

    AST_ONE_VEH_LAMP: assert property (@(posedge clk) disable iff (rst)
        $countones({veh_grn, veh_amb, veh_red}) == 1); // R4
    AST_PED_LAMPS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ped_grn && ped_red)); // R4
    AST_PED_GRN_VEH_RED: assert property (@(posedge clk) disable iff (rst)
        ped_grn |-> veh_red); // R4
    AST_BLANK_OUTSIDE_CROSS: assert property (@(posedge clk) disable iff (rst)
        !in_cross_q |-> (dig_hi == DIGIT_BLANK && dig_lo == DIGIT_BLANK)); // R9
    AST_WARN_DARK_HALF: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_WARN && ctl_q.blink) |-> (!ped_grn && !ped_red && dig_lo == DIGIT_BLANK)); // R6
    AST_AMBER_AFTER_GREEN: assert property (@(posedge clk) disable iff (rst)
        $rose(veh_amb) |-> $past(veh_grn)); // R2
    AST_IDLE_SEQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_IDLE && $past(ctl_q.st) == ST_IDLE) |-> seq_q == SEQ_W'(SEQ_LOAD)); // R8

endmodule

// File: tb/sim_ped_xing_ctrl.sv
module sim_ped_xing_ctrl;
    logic clk = 1'b0, rst = 1'b1, req_btn = 1'b0, sec_tick = 1'b0, blink_tick = 1'b0;
    logic veh_grn, veh_amb, veh_red, ped_grn, ped_red;
    logic [3:0] dig_hi, dig_lo;

    int n_vec = 0, n_bad = 0, gc = 0, tick_per = 4;
    bit done = 0;

    // behavioural reference: 0 idle,1 amber,2 clear-in,3 walk,4 warn,5 clear-out
    int m_st = 0, m_seq = 25, m_x = 15;
    bit m_blink = 0, m_pend = 0;

    ped_xing_ctrl u0 (.clk(clk), .rst(rst), .req_btn(req_btn), .sec_tick(sec_tick),
        .blink_tick(blink_tick), .veh_grn(veh_grn), .veh_amb(veh_amb), .veh_red(veh_red),
        .ped_grn(ped_grn), .ped_red(ped_red), .dig_hi(dig_hi), .dig_lo(dig_lo));

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int n_st, n_seq, n_x;
        bit n_blink, n_pend;
        if (rst) begin
            m_st = 0; m_seq = 25; m_x = 15; m_blink = 0; m_pend = 0;
        end else begin
            n_st = m_st; n_seq = m_seq; n_x = m_x;
            n_blink = blink_tick ? !m_blink : m_blink;
            n_pend = m_pend | req_btn;
            if (m_st == 0) begin
                n_seq = 25;
                if (m_pend || req_btn) begin n_st = 1; n_pend = 0; end
            end else if (sec_tick) begin
                n_seq = (m_seq == 0) ? 25 : m_seq - 1;
                if (m_st == 1 && m_seq == 23) n_st = 2;
                if (m_st == 2 && m_seq == 22) n_st = 3;
                if (m_st == 3 && m_seq == 7)  n_st = 4;
                if (m_st == 4 && m_seq == 2)  n_st = 5;
                if (m_st == 5 && m_seq == 1)  n_st = 0;
            end
            if (m_st == 3) begin
                if (sec_tick) n_x = (m_x == 0) ? 15 : m_x - 1;
            end else if (m_st != 4) n_x = 15;
            m_st = n_st; m_seq = n_seq; m_x = n_x; m_blink = n_blink; m_pend = n_pend;
        end
    end

    always @(negedge clk) begin
        bit show;
        int e_pack, a_pack;
        string tag;
        if (!done) begin
            show = (m_st == 3) || (m_st == 4 && !m_blink);
            e_pack = {(m_st == 0), (m_st == 1), (m_st >= 2), show,
                      (m_st != 3 && m_st != 4),
                      show ? 4'(m_x / 10) : 4'hF, show ? 4'(m_x % 10) : 4'hF};
            a_pack = {veh_grn, veh_amb, veh_red, ped_grn, ped_red, dig_hi, dig_lo};
            case (m_st)
                0: tag = "R1 idle";
                1: tag = "R2/R3 amber";
                3: tag = "R5 walk";
                4: tag = "R6 warn";
                default: tag = "R3 clearance";
            endcase
            check(a_pack === e_pack, tag, a_pack, e_pack);
            check($countones({veh_grn, veh_amb, veh_red}) == 1 && !(ped_grn && ped_red),
                  "R4 lamp exclusivity", {veh_grn, veh_amb, veh_red, ped_grn, ped_red}, 0);
            if (m_st != 3 && m_st != 4)
                check({dig_hi, dig_lo} == 8'hFF, "R9 blank digits", {dig_hi, dig_lo}, 8'hFF);
        end
    end

    task automatic cyc(input bit req);
        @(negedge clk);
        req_btn    = req;
        sec_tick   = (gc % tick_per == 0);
        blink_tick = (gc % 3 == 1);
        gc++;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int guard;
        repeat (3) cyc(0);
        check(veh_grn && ped_red && dig_hi == 4'hF && dig_lo == 4'hF, "R1 during reset",
              {veh_grn, ped_red, dig_hi}, 'h3F);
        rst = 0;
        // R8: idle ticks ignored
        repeat (40) cyc(0);
        check(veh_grn == 1, "R8 idle holds green", veh_grn, 1);
        // R2: request
        cyc(1);
        cyc(0);
        check(veh_amb == 1 && veh_grn == 0, "R2 amber after request", veh_amb, 1);
        // run to walk, R5 entry value
        guard = 0;
        while (!ped_grn && guard < 200) begin cyc(0); guard++; end
        check(dig_hi == 1 && dig_lo == 5, "R5 walk entry digits", {dig_hi, dig_lo}, 'h15);
        // R7: request during walk
        cyc(1);
        guard = 0;
        while (!veh_grn && guard < 400) begin cyc(0); guard++; end
        check(veh_grn == 1, "R3 return to idle", veh_grn, 1);
        cyc(0);
        check(veh_amb == 1, "R7 latched request served", veh_amb, 1);
        // faster ticks, run into walk then reset with a pending request
        tick_per = 2;
        guard = 0;
        while (!ped_grn && guard < 200) begin cyc(0); guard++; end
        cyc(1);
        repeat (3) cyc(0);
        rst = 1;
        cyc(0);
        rst = 0;
        cyc(0);
        check(veh_grn == 1, "R10 reset returns to idle", veh_grn, 1);
        repeat (30) cyc(0);
        check(veh_grn == 1, "R10 pending request discarded", veh_grn, 1);
        // one more full sequence with tick every cycle
        tick_per = 1;
        cyc(1);
        repeat (40) cyc(0);
        check(veh_grn == 1, "R3 full sequence ends in idle", veh_grn, 1);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule